// File: doc/BRIEF.md
# Pseudo-ternary line frame encoder

The block turns per-frame channel data into a 48-bit basic-access line frame and sends it one bit per bit-rate strobe on a pseudo-ternary line. The line is a pair of registered pulse outputs, one for positive and one for negative marks. Each frame carries 36 user bits: two octets for each of the two bearer channels and four signalling bits. The other 12 bits are frame overhead: a framing bit, an auxiliary framing bit, DC-balance bits and fixed idle ONEs.

A ONE is sent as no pulse. Each ZERO is a pulse whose polarity is the opposite of the one before it. The exceptions are the framing bit and the auxiliary framing bit. Each of these is a ZERO sent with the same polarity as the previous pulse, and so forms a code violation that a receiver locks to. A direction input selects network-side timing, or terminal-side timing in which the frame start lags the reference count by two bit periods.

Top module: `st_line_encoder`

## Requirements
- R1: A ONE bit drives both `pos_o` and `neg_o` low for its whole bit period.
- R2: Every data bit or balance bit that is a ZERO is sent as a single pulse whose polarity is opposite to the previous pulse on the line.
- R3: Frame bit 0 is a ZERO pulse with the same polarity as the previous pulse. After reset, the previous pulse counts as negative, so the first framing pulse is on `neg_o`.
- R4: Frame bit 13 is a ZERO pulse with the same polarity as the previous pulse. Bits 0 and 13 are the only places where two pulses in a row share a polarity.
- R5: A frame is 48 strobes long. `frame_start_o` is high for exactly the strobe period that sends bit 0, so successive rises are 48 strobes apart.
- R6: Data positions, each octet sent MSB first: `frame_i[35:28]` at bits 2..9, `frame_i[19:12]` at bits 15..22, `frame_i[27:20]` at bits 26..33 and `frame_i[11:4]` at bits 35..42. The four signalling bits go out as `frame_i[3]` at bit 11, `frame_i[2]` at bit 24, `frame_i[1]` at bit 34 and `frame_i[0]` at bit 43.
- R7: Bits 1, 10, 12, 23, 25 and 44 are balance bits. Each one is a ZERO exactly when the number of ZEROs sent since the previous balance bit is odd. For bit 1, that count starts at bit 0.
- R8: Bits 14, 45, 46 and 47 are always ONE.
- R9: `frame_i` is captured on the strobe that sends bit 47 and is used for the next frame. The first frame after reset carries all-ONE data unless a bit-47 capture came before it.
- R10: With `dir_i`=0, bit 0 goes out on the first strobe after reset. With `dir_i`=1, it goes out on the third strobe, and the two strobes before it send no pulse. `dir_i` is held constant between resets.
- R11: The outputs are low in reset, change only on the clock edge that follows a strobe, and `pos_o` and `neg_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-rate strobe, one clock wide |
| dir_i | input | 1 | 0 selects network-side timing, 1 selects terminal-side timing (two-bit lag) |
| frame_i | input | 36 | Channel data for the next frame |
| pos_o | output | 1 | Positive mark |
| neg_o | output | 1 | Negative mark |
| frame_start_o | output | 1 | High during bit 0 of each frame |

## Verification
On the strobe that sends bit 47, two things happen in the same cycle: the last bit of the current frame goes out, and the data register loads the following frame. The bench changes `frame_i` right after that edge. A capture on the wrong edge would therefore mix two frames, and the pulse train decoded back into bits is compared with the data the scoreboard queued for each frame. Forcing the violation at bit 0 also resets the balance parity in that same cycle. This is judged by checking that every balance bit leaves an even ZERO count, and that a violation appears only at bits 0 and 13, in both directions.

// File: rtl/st_line_pkg.sv
package st_line_pkg;
  localparam int FRAME_LEN = 48;
  localparam int OCT_W     = 8;
  localparam int SIG_W     = 4;
  localparam int DATA_W    = 4 * OCT_W + SIG_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int SEL_W     = $clog2(DATA_W);

  typedef enum logic [2:0] {
    SLOT_FRM,
    SLOT_AUX,
    SLOT_BAL,
    SLOT_DAT,
    SLOT_IDLE
  } slot_e;

  function automatic slot_e slot_kind(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      0:                     return SLOT_FRM;
      13:                    return SLOT_AUX;
      1, 10, 12, 23, 25, 44: return SLOT_BAL;
      14, 45, 46, 47:        return SLOT_IDLE;
      default:               return SLOT_DAT;
    endcase
  endfunction

  // frame position -> bit of the data word
  function automatic logic [SEL_W-1:0] data_sel(input logic [IDX_W-1:0] idx);
    int i;
    int r;
    i = int'(idx);
    r = 0;
    if (i >= 2 && i <= 9)        r = DATA_W - 1 - (i - 2);
    else if (i >= 15 && i <= 22) r = DATA_W - 1 - 2 * OCT_W - (i - 15);
    else if (i >= 26 && i <= 33) r = DATA_W - 1 - OCT_W - (i - 26);
    else if (i >= 35 && i <= 42) r = DATA_W - 1 - 3 * OCT_W - (i - 35);
    else if (i == 11)            r = SIG_W - 1;
    else if (i == 24)            r = SIG_W - 2;
    else if (i == 34)            r = SIG_W - 3;
    else                         r = 0;
    return SEL_W'(r);
  endfunction
endpackage

// File: rtl/st_frame_timer.sv
module st_frame_timer
  import st_line_pkg::*;
#(
  parameter int LEN   = FRAME_LEN,
  parameter int DELAY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             dir_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int SW = IDX_W + 1;

  logic [IDX_W-1:0] ref_q;
  logic [SW-1:0]    sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ref_q <= '0;
    else if (bit_en_i) ref_q <= (ref_q == IDX_W'(LEN - 1)) ? '0 : ref_q + 1'b1;
  end

  // the lagging direction runs DELAY bits behind the reference count
  always_comb begin
    sum = {1'b0, ref_q} + (dir_i ? SW'(LEN - DELAY) : '0);
    if (sum >= SW'(LEN)) idx_o = IDX_W'(sum - SW'(LEN));
    else                 idx_o = sum[IDX_W-1:0];
  end
endmodule

// File: rtl/st_frame_store.sv
module st_frame_store
  import st_line_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] frame_i,
  output logic [DATA_W-1:0] data_o
);
  logic take;

  assign take = bit_en_i && (idx_i == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '1;
    else if (take) data_o <= frame_i;
  end
endmodule

// File: rtl/st_slot_mux.sv
module st_slot_mux
  import st_line_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output slot_e             kind_o,
  output logic              dbit_o,
  output logic              first_o
);
  always_comb begin
    kind_o  = slot_kind(idx_i);
    dbit_o  = data_i[data_sel(idx_i)];
    first_o = (idx_i == '0);
  end
endmodule

// File: rtl/st_line_coder.sv
module st_line_coder
  import st_line_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_en_i,
  input  slot_e kind_i,
  input  logic  dbit_i,
  input  logic  first_i,
  output logic  pos_o,
  output logic  neg_o,
  output logic  frame_start_o
);
  logic started_q, last_neg_q, acc_q;
  logic emit, zero, forced, pol_neg;

  always_comb begin
    forced = (kind_i == SLOT_FRM) || (kind_i == SLOT_AUX);
    emit   = started_q | first_i;
    case (kind_i)
      SLOT_FRM, SLOT_AUX: zero = 1'b1;
      SLOT_BAL:           zero = acc_q;
      SLOT_IDLE:          zero = 1'b0;
      default:            zero = ~dbit_i;
    endcase
    pol_neg = forced ? last_neg_q : ~last_neg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o         <= 1'b0;
      neg_o         <= 1'b0;
      frame_start_o <= 1'b0;
      started_q     <= 1'b0;
      last_neg_q    <= 1'b1;
      acc_q         <= 1'b0;
    end else if (bit_en_i) begin
      if (emit) begin
        pos_o         <= zero & ~pol_neg;
        neg_o         <= zero & pol_neg;
        frame_start_o <= first_i;
        started_q     <= 1'b1;
        if (zero) last_neg_q <= pol_neg;
        if (first_i)                 acc_q <= zero;
        else if (kind_i == SLOT_BAL) acc_q <= 1'b0;
        else                         acc_q <= acc_q ^ zero;
      end else begin
        pos_o         <= 1'b0;
        neg_o         <= 1'b0;
        frame_start_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/st_line_encoder.sv
module st_line_encoder
  import st_line_pkg::*;
#(
  parameter int TE_DELAY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] frame_i,
  output logic              pos_o,
  output logic              neg_o,
  output logic              frame_start_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] data;
  slot_e             kind;
  logic              dbit, first;

  st_frame_timer #(.LEN(FRAME_LEN), .DELAY(TE_DELAY)) u_timer (
    .clk_i, .rst_ni, .bit_en_i, .dir_i, .idx_o(idx)
  );

  st_frame_store u_store (
    .clk_i, .rst_ni, .bit_en_i, .idx_i(idx), .frame_i, .data_o(data)
  );

  st_slot_mux u_mux (
    .idx_i(idx), .data_i(data), .kind_o(kind), .dbit_o(dbit), .first_o(first)
  );

  st_line_coder u_coder (
    .clk_i, .rst_ni, .bit_en_i, .kind_i(kind), .dbit_i(dbit), .first_i(first),
    .pos_o, .neg_o, .frame_start_o
  );
endmodule

// File: rtl/st_line_encoder_chk.sv
module st_line_encoder_chk
  import st_line_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic pos_o,
  input logic neg_o,
  input logic frame_start_o
);
  localparam int CW = $clog2(FRAME_LEN + 1) + 1;

  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          fs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
      fs_d   <= 1'b0;
    end else begin
      fs_d <= frame_start_o;
      if (frame_start_o) seen_q <= 1'b1;
      if (frame_start_o && !fs_d) cnt_q <= bit_en_i ? CW'(1) : '0;
      else if (bit_en_i)          cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_NO_DUAL_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && neg_o)); // R11

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable({pos_o, neg_o, frame_start_o})); // R11

  AST_FRAME_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (pos_o || neg_o)); // R3

  AST_QUIET_LEADIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !frame_start_o) |-> !(pos_o || neg_o)); // R10

  AST_FRAME_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && !fs_d && seen_q) |-> (cnt_q == CW'(FRAME_LEN))); // R5
endmodule

bind st_line_encoder st_line_encoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
  .pos_o(pos_o), .neg_o(neg_o), .frame_start_o(frame_start_o)
);

// File: tb/st_line_encoder_tb.sv
module st_line_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        dir = 1'b0;
  logic [35:0] frame = '0;
  logic        pos, neg, fs;

  always #4 clk = ~clk;

  st_line_encoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .dir_i(dir),
    .frame_i(frame), .pos_o(pos), .neg_o(neg), .frame_start_o(fs)
  );

  typedef struct {
    logic        pos;
    logic        neg;
    logic        fs;
    logic        emit;
    int          t;
    logic [35:0] data;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  // scoreboard model state
  int          m_k, pat_n;
  logic        m_started, m_lastneg, m_acc;
  logic [35:0] m_shadow;
  // monitor state
  int          mon_k, mon_lastfs;
  logic        mon_started, mon_prevneg, mon_acc;
  logic [35:0] rec;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // 0 framing, 1 aux framing, 2 balance, 3 data, 4 idle one
  function automatic int b_kind(input int t);
    if (t == 0) return 0;
    if (t == 13) return 1;
    if (t == 1 || t == 10 || t == 12 || t == 23 || t == 25 || t == 44) return 2;
    if (t == 14 || t >= 45) return 4;
    return 3;
  endfunction

  function automatic int b_pos(input int t);
    if (t == 11) return 3;
    if (t == 24) return 2;
    if (t == 34) return 1;
    if (t == 43) return 0;
    if (t <= 9)  return 28 + (9 - t);
    if (t <= 22) return 12 + (22 - t);
    if (t <= 33) return 20 + (33 - t);
    return 4 + (42 - t);
  endfunction

  function automatic logic [35:0] pat(input int n);
    case (n % 5)
      0: return 36'h0;
      1: return 36'hF_FFFF_FFFF;
      2: return 36'h5_A5A5_A5A5;
      3: return {8'h01, 8'h80, 8'hFF, 8'h00, 4'b1010};
      default: return 36'h1_2345_6789;
    endcase
  endfunction

  task automatic strobe();
    exp_t e;
    int   t, k;
    logic zero, pn;
    t = dir ? (m_k + 46) % 48 : m_k % 48;
    k = b_kind(t);
    e.t = t;
    e.data = m_shadow;
    e.emit = m_started || (t == 0);
    e.pos = 1'b0; e.neg = 1'b0; e.fs = 1'b0;
    if (e.emit) begin
      case (k)
        0, 1:    zero = 1'b1;
        2:       zero = m_acc;
        4:       zero = 1'b0;
        default: zero = ~m_shadow[b_pos(t)];
      endcase
      pn = (k <= 1) ? m_lastneg : ~m_lastneg;
      e.pos = zero & ~pn;
      e.neg = zero & pn;
      e.fs = (t == 0);
      if (zero) m_lastneg = pn;
      if (t == 0)      m_acc = zero;
      else if (k == 2) m_acc = 1'b0;
      else             m_acc = m_acc ^ zero;
      m_started = 1'b1;
    end
    q.push_back(e);
    @(negedge clk); bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    if (t == 47) begin
      m_shadow = frame;  // R9 captured at that edge
      pat_n++;
      frame = pat(pat_n);
    end
    m_k++;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops one expected item per strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bit_en === 1'b1) begin
        exp_t e;
        logic p0, n0, f0, zero, viol;
        int   k;
        @(negedge clk);
        if (q.size() == 0) begin
          chk(1'b0, "R5", "unexpected strobe", 0, 1);
        end else begin
          e = q.pop_front();
          k = b_kind(e.t);
          p0 = pos; n0 = neg; f0 = fs;
          chk({pos, neg} == {e.pos, e.neg},
              !e.emit ? "R10" : (k == 0) ? "R3" : (k == 1) ? "R4" :
              (!e.pos && !e.neg) ? "R1" : "R2",
              "pulse pair", {pos, neg}, {e.pos, e.neg});
          chk(fs == e.fs, "R5", "frame_start", fs, e.fs);
          chk(!(pos && neg), "R11", "both marks", {pos, neg}, 0);
          if (fs) begin
            mon_started = 1'b1;
            if (mon_lastfs >= 0)
              chk(mon_k - mon_lastfs == 48, "R5", "frame period", mon_k - mon_lastfs, 48);
            mon_lastfs = mon_k;
          end
          if (mon_started) begin
            zero = pos | neg;
            viol = zero && (neg == mon_prevneg);
            if (e.t == 0)       chk(viol, "R3", "framing violation", viol, 1);
            else if (e.t == 13) chk(viol, "R4", "aux violation", viol, 1);
            else if (zero)      chk(!viol, "R4", "stray violation", e.t, 0);
            if (zero) mon_prevneg = neg;
            if (k == 3) rec[b_pos(e.t)] = ~zero;
            if (k == 4) chk(!zero, "R8", "idle bit", e.t, 0);
            if (e.t == 0) mon_acc = zero;
            else if (k == 2) begin
              chk((mon_acc ^ zero) == 1'b0, "R7", "balance parity", e.t, 0);
              mon_acc = 1'b0;
            end else mon_acc = mon_acc ^ zero;
            if (e.t == 47) chk(rec == e.data, "R6 R9", "recovered data", rec, e.data);
          end
          mon_k++;
          @(negedge clk);
          chk({pos, neg, fs} == {p0, n0, f0}, "R11", "hold between strobes",
              {pos, neg, fs}, {p0, n0, f0});
        end
      end
    end
  end

  task automatic run(input logic d, input int nf);
    @(negedge clk);
    rst_n = 1'b0;
    dir = d;
    pat_n = 0;
    frame = pat(0);
    m_k = 0; m_started = 1'b0; m_lastneg = 1'b1; m_acc = 1'b0; m_shadow = '1;
    mon_k = 0; mon_lastfs = -1; mon_started = 1'b0; mon_prevneg = 1'b1; mon_acc = 1'b0;
    rec = '0;
    q.delete();
    repeat (2) @(negedge clk);
    chk({pos, neg, fs} == 3'b000, "R11", "reset outputs", {pos, neg, fs}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pos, neg, fs} == 3'b000, "R11", "idle after reset", {pos, neg, fs}, 0);
    repeat (nf * 48 + (d ? 2 : 0)) strobe();
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R5", "queue drained", q.size(), 0);
  endtask

  initial begin
    run(1'b0, 6);  // R10 network-side timing
    run(1'b1, 5);  // R10 terminal-side two-bit lag
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL R5 watchdog expired act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule